// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block passes data between two 18-bit ports, an A side and a B side. Each direction has its own enable, storage-mode control and capture clock. One storage element per bit sits in each direction. The storage-mode control decides how that element behaves. With the control high, the element is open and the far port follows the near port in the same cycle. With the control low, the element holds its contents, or loads new data when the direction's capture clock rises. The capture clock is sampled by the free-running system clock, so the whole design stays synchronous.

The ports use plain vectors instead of tri-state pins. Each side has an input vector and a per-bit driven flag. The block returns an output vector and a per-bit drive-enable vector. A per-bit keeper on each input side stands in for an undriven bit: it supplies the last level that bit had while it was driven. If both directions are enabled at once, each port still takes its value from its own path, and a contention flag is raised.

Top module: `bus_xcvr18`

## Requirements
- R1: While a direction's enable input is low, the port that direction drives has its drive-enable vector at all zeros and its data vector at all zeros. The other direction is unaffected.
- R2: With a direction enabled and its storage-mode control high, the far port shows the near port's seen data in the same cycle. Every change is visible before the next system clock edge.
- R3: With the storage-mode control low, a rising capture clock loads the seen data at that system clock edge, and the far port shows it from then on. A rising capture clock means the sample is high at this edge and was low at the previous edge.
- R4: With the storage-mode control low and no rising capture clock, the stored value and the far port's data stay unchanged, whatever the near port does.
- R5: Once the storage-mode control falls, the element keeps the data seen at the last system clock edge at which the control was high. If the capture clock was high when the control fell, nothing new is loaded until the clock goes low and then high again. If the capture clock was low, its next rise loads new data.
- R6: The B-to-A direction follows R2 to R5 with its own enable, storage-mode control and capture clock, and is independent of the A-to-B direction.
- R7: On each input side, a bit whose driven flag is 0 is seen at the last level it had while its flag was 1. Bits are handled independently, and the keepers reset to 0.
- R8: The asynchronous active-low reset clears both storage elements and both keepers. Both drive-enable vectors stay at zero until the first system clock edge after reset is released. The sampled capture clocks reset high, so a clock held high through reset produces no capture.
- R9: When both directions are enabled at once, both drive-enable vectors are all ones, each port carries its own direction's value, and the contention output is 1. Otherwise contention is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | A-side data as it arrives |
| a_drv | input | 18 | Per-bit flag, 1 where an A bit is being driven |
| a_out | output | 18 | Data the block puts on the A side |
| a_oe | output | 18 | Per-bit drive enable for the A side |
| b_in | input | 18 | B-side data as it arrives |
| b_drv | input | 18 | Per-bit flag, 1 where a B bit is being driven |
| b_out | output | 18 | Data the block puts on the B side |
| b_oe | output | 18 | Per-bit drive enable for the B side |
| ab_oe | input | 1 | Enable for the A-to-B direction |
| ab_le | input | 1 | A-to-B storage mode: 1 open, 0 hold or capture |
| ab_ck | input | 1 | A-to-B capture clock, sampled by clk |
| ba_oe | input | 1 | Enable for the B-to-A direction |
| ba_le | input | 1 | B-to-A storage mode: 1 open, 0 hold or capture |
| ba_ck | input | 1 | B-to-A capture clock, sampled by clk |
| contention | output | 1 | High while both directions drive |

## Verification
Open-mode transfers, enable changes, keeper substitution and the contention flag have no register on the way, so they are due in the same cycle as the stimulus. The bench checks them 1 ns after changing the inputs, well before the next clock edge. A capture or a hold needs one system clock edge: the edge that sees the capture clock high after a low sample, or the edge after the storage-mode control falls. The bench therefore drives 1 ns after a rising edge and reads the registered result 1 ns after the following edge. The enable gating after reset also takes exactly one edge, and the bench checks the port both before and after that edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    SM_PASS    = 2'd0,
    SM_HOLD    = 2'd1,
    SM_CAPTURE = 2'd2
  } store_mode_e;

  // storage mode chosen from the level control and the detected clock rise
  function automatic store_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return SM_PASS;
    else if (rise) return SM_CAPTURE;
    else           return SM_HOLD;
  endfunction

  // one bit as seen through the keeper
  function automatic logic keep_bit(input logic drv, input logic din, input logic held);
    return drv ? din : held;
  endfunction

  // rising edge from current and previous sample
  function automatic logic is_rise(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction

endpackage

// File: rtl/xcvr_clk_edge.sv
module xcvr_clk_edge
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ck_i,
  output logic rise_o
);

  logic ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b1;
    else        ck_q <= ck_i;
  end

  assign rise_o = is_rise(ck_i, ck_q);

  // R3: a rising sample cannot be reported on two edges in a row
  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic         rise_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output store_mode_e  mode_o
);

  logic [W-1:0] q;
  store_mode_e  mode;

  assign mode   = pick_mode(le_i, rise_i);
  assign mode_o = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (mode)
        SM_PASS:    q <= din_i;
        SM_CAPTURE: q <= din_i;
        default:    q <= q;
      endcase
    end
  end

  assign dout_o = (mode == SM_PASS) ? din_i : q;

  // R4: hold keeps the stored word
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_HOLD) |=> (q == $past(q)));

  // R3: capture loads the word present at that edge
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_CAPTURE) |=> (q == $past(din_i)));

  // R5: after an open cycle the element holds what it saw then
  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_PASS) |=> (q == $past(din_i)));

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] seen_o
);

  logic [W-1:0] held_q;
  logic         live_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign seen_o[i] = keep_bit(drv_i[i], din_i[i], held_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held_q[i] <= 1'b0;
      else if (drv_i[i]) held_q[i] <= din_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R7: an undriven bit keeps the level it was last seen at
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> (((seen_o ^ $past(seen_o)) & ~drv_i) == '0));

  // R7: a driven bit is seen as driven
  p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen_o ^ din_i) & drv_i) == '0);

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic         ck_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  logic        rise;
  store_mode_e mode;

  xcvr_clk_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ck_i   (ck_i),
    .rise_o (rise)
  );

  xcvr_store #(.W(W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_i   (le_i),
    .rise_i (rise),
    .din_i  (din_i),
    .dout_o (dout_o),
    .mode_o (mode)
  );

  // R4: a closed element with no rise leaves the output steady
  p_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && !rise) |=> (!le_i && !rise) |-> $stable(dout_o));

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ba_oe,
  input  logic         ba_le,
  input  logic         ba_ck,
  output logic         contention
);

  localparam int NDIR = 2;

  logic [W-1:0] a_seen, b_seen;
  logic [W-1:0] dir_din  [NDIR];
  logic [W-1:0] dir_dout [NDIR];
  logic         dir_le   [NDIR];
  logic         dir_ck   [NDIR];
  logic         dir_en   [NDIR];
  logic         armed_q;

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk (clk), .rst_n (rst_n), .din_i (a_in), .drv_i (a_drv), .seen_o (a_seen)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk (clk), .rst_n (rst_n), .din_i (b_in), .drv_i (b_drv), .seen_o (b_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // index 0: A to B, index 1: B to A
  assign dir_din[0] = a_seen;
  assign dir_din[1] = b_seen;
  assign dir_le[0]  = ab_le;
  assign dir_le[1]  = ba_le;
  assign dir_ck[0]  = ab_ck;
  assign dir_ck[1]  = ba_ck;
  assign dir_en[0]  = armed_q & ab_oe;
  assign dir_en[1]  = armed_q & ba_oe;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_dir #(.W(W)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .le_i   (dir_le[d]),
      .ck_i   (dir_ck[d]),
      .din_i  (dir_din[d]),
      .dout_o (dir_dout[d])
    );
  end

  assign b_out      = dir_en[0] ? dir_dout[0] : '0;
  assign b_oe       = {W{dir_en[0]}};
  assign a_out      = dir_en[1] ? dir_dout[1] : '0;
  assign a_oe       = {W{dir_en[1]}};
  assign contention = dir_en[0] & dir_en[1];

  // R1: a disabled direction leaves its port quiet
  p_idle_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_oe |-> (b_oe == '0 && b_out == '0));
  p_idle_ba_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_oe |-> (a_oe == '0 && a_out == '0));

  // R2: open element passes the seen data straight through
  p_pass_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ab_oe && ab_le) |-> (b_out == a_seen));
  p_pass_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ba_oe && ba_le) |-> (a_out == b_seen));

  // R8: nothing drives before the first edge after reset
  p_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (a_oe == '0 && b_oe == '0));

  // R9: the flag agrees with both ports driving
  p_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    contention |-> (&a_oe && &b_oe));
  p_contend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ab_oe && ba_oe) |-> contention);

endmodule

// File: tb/sim_bus_xcvr18.sv
module sim_bus_xcvr18;

  localparam int W = 18;
  localparam int WD_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, a_drv = '0, b_in = '0, b_drv = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         ab_oe = 0, ab_le = 0, ab_ck = 1, ba_oe = 0, ba_le = 0, ba_ck = 1;
  logic         contention;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_xcvr18 #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_ck(ab_ck),
    .ba_oe(ba_oe), .ba_le(ba_le), .ba_ck(ba_ck),
    .contention(contention)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    ab_oe = 1; ab_le = 1; a_in = '1; a_drv = '0;
    ba_oe = 0; ba_le = 0; ab_ck = 1; ba_ck = 1;
    repeat (3) tick();
    rst_n = 1;
    #1;
    chk("R8 b_oe before first edge", b_oe, '0);
    chk("R8 contention quiet", {17'd0, contention}, '0);
    tick();
    chk("R8 b_oe after first edge", b_oe, '1);
    chk("R7 keeper reset value", b_out, '0);
    chk("R1 a side idle", a_oe, '0);
  endtask

  task automatic t_pass();
    a_drv = '1; a_in = 18'h15A3C;
    #1 chk("R2 pass first", b_out, 18'h15A3C);
    a_in = 18'h2C3F1;
    #1 chk("R2 pass second", b_out, 18'h2C3F1);
  endtask

  task automatic t_close_high();
    ab_le = 1; ab_ck = 1; a_in = 18'h11111;
    tick();
    ab_le = 0; a_in = 18'h22222;
    #1 chk("R5 held after close", b_out, 18'h11111);
    tick(); tick();
    chk("R4 steady clock high", b_out, 18'h11111);
    ab_ck = 0;
    tick();
    ab_ck = 1;
    #1 chk("R4 before capturing edge", b_out, 18'h11111);
    tick();
    chk("R3 capture on rise", b_out, 18'h22222);
    a_in = 18'h33333;
    tick();
    chk("R4 no recapture while high", b_out, 18'h22222);
  endtask

  task automatic t_close_low();
    ab_le = 1; ab_ck = 0; a_in = 18'h0ABCD;
    tick();
    ab_le = 0; a_in = 18'h3FFFF;
    tick();
    chk("R5 held with clock low", b_out, 18'h0ABCD);
    ab_ck = 1;
    tick();
    chk("R5 next rise loads", b_out, 18'h3FFFF);
  endtask

  task automatic t_keeper();
    ab_le = 1; a_drv = '1; a_in = 18'h2A5A5;
    tick();
    a_drv = 18'h0FFFF; a_in = '0;
    #1 chk("R7 undriven bits kept", b_out, 18'h20000);
    a_in = '1;
    #1 chk("R7 driven bits follow", b_out, 18'h2FFFF);
    tick();
    chk("R7 keeper unchanged by undriven input", b_out, 18'h2FFFF);
    a_drv = '1;
  endtask

  task automatic t_idle();
    ab_oe = 0;
    #1;
    chk("R1 b_oe off", b_oe, '0);
    chk("R1 b_out zero", b_out, '0);
  endtask

  task automatic t_reverse();
    ba_oe = 1; ba_le = 1; b_drv = '1; b_in = 18'h13579;
    #1 chk("R6 pass toward A", a_out, 18'h13579);
    chk("R1 B side stays idle", b_oe, '0);
    tick();
    ba_le = 0; ba_ck = 0; b_in = 18'h02468;
    tick();
    chk("R6 hold toward A", a_out, 18'h13579);
    ba_ck = 1;
    tick();
    chk("R6 capture toward A", a_out, 18'h02468);
  endtask

  task automatic t_contend();
    ab_oe = 1; ab_le = 1; a_in = 18'h00F0F;
    #1;
    chk("R9 flag set", {17'd0, contention}, 18'd1);
    chk("R9 a_oe all ones", a_oe, '1);
    chk("R9 b_oe all ones", b_oe, '1);
    chk("R9 each port own path", b_out, 18'h00F0F);
    chk("R9 A keeps its path", a_out, 18'h02468);
    ba_oe = 0;
    #1 chk("R9 flag clear", {17'd0, contention}, 18'd0);
  endtask

  task automatic run_all();
    t_reset();
    t_pass();
    t_close_high();
    t_close_low();
    t_keeper();
    t_idle();
    t_reverse();
    t_contend();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule